// File: doc/BRIEF.md
# Byte-Lane Table-Write Bus Interface

This block turns a single table-write request from the processor side into one write cycle on a multiplexed 16-bit address/data bus, so that one byte lands in a word-wide external memory. A request carries a 21-bit byte pointer, an 8-bit data byte and a one-clock start pulse. Pointer bits [20:1] form the word address. The low sixteen bits of that address go out on the shared AD lines while the address latch enable is high. The remaining four bits go out on separate upper address lines.

In the data phase the byte is copied onto both halves of the AD bus, and the high write strobe is pulsed. The low write strobe is never used. Pointer bit 0 selects which half of the word is written. For Flash-style parts that bit is driven on a byte-address output. For SRAM-style parts it picks which of two active-low byte enables is asserted. A configuration input selects the style. The block also drives the style onto a byte/word mode output, which a Flash-style part needs held in byte mode.

Each cycle has four phases of one clock each: address, latch, data and release. A busy flag covers all four phases. A done pulse follows in the next clock. A start pulse that arrives while the block is busy is dropped. The pointer, data and style are all captured when the request is accepted.

Top module: `bsw_wr_if`

## Requirements
- R1: After reset, and while idle, the block holds these output values: address latch enable low, AD not driven (ad_oe_o low, ad_o zero), upper address zero, both write strobes high, byte address 0, both byte enables high, busy low and done low.
- R2: In the first clock after an accepted start, the address latch enable is high and AD is driven with pointer bits [16:1]. The upper address lines carry pointer bits [20:17] and busy is high.
- R3: In the second clock the address latch enable is low and AD still carries pointer bits [16:1].
- R4: In the third clock AD is driven with the data byte on bits [15:8] and on bits [7:0]. The high write strobe is low in this clock only, exactly once per cycle.
- R5: The low write strobe never goes low.
- R6: In SRAM style (sram_mode_i = 1), during the data phase only, pointer bit 0 = 0 drives be_n_o[0] (lower byte) low with be_n_o[1] high. Pointer bit 0 = 1 drives be_n_o[1] (upper byte) low with be_n_o[0] high.
- R7: In Flash style (sram_mode_i = 0), both byte enables stay high, and ba_o equals pointer bit 0 from the address phase through the release phase. In SRAM style ba_o stays 0.
- R8: byte_mode_n_o equals sram_mode_i, so it is low (byte mode) in Flash style.
- R9: The fourth clock is a release phase: AD is not driven, the strobes are high and busy is still high. In the following clock done is high for one clock and busy is low.
- R10: A start pulse that arrives while busy is ignored. It does not alter the current cycle and does not begin another one.
- R11: The pointer, data byte and style are sampled when a start is accepted. Changes to them during the cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-clock request to write a byte |
| ptr_i | input | 21 | Byte pointer |
| data_i | input | 8 | Byte to write |
| sram_mode_i | input | 1 | 1: SRAM-style byte enables, 0: Flash-style byte address |
| ad_o | output | 16 | Multiplexed address/data value |
| ad_oe_o | output | 1 | Drive enable for the AD lines |
| up_o | output | 4 | Upper word-address bits |
| ale_o | output | 1 | Address latch enable, active high |
| wrh_n_o | output | 1 | High write strobe, active low |
| wrl_n_o | output | 1 | Low write strobe, active low, held inactive |
| ba_o | output | 1 | Flash-style byte address |
| be_n_o | output | 2 | SRAM byte enables, active low; bit 0 lower, bit 1 upper |
| byte_mode_n_o | output | 1 | Byte/word mode pin drive, low selects byte mode |
| busy_o | output | 1 | Write cycle in progress |
| done_o | output | 1 | One-clock pulse after the release phase |

## Verification
The hardest condition to reach from the ports is a new request that arrives in the middle of a cycle, together with a pointer, data byte and style that all change at the same time. In such a run, a design that re-samples its inputs or restarts would still produce outputs that look correct. Some randomly chosen writes therefore raise start again one clock into the cycle, invert every request input, and hold start high until the release phase. The bench then checks that every remaining phase still reflects the original request, and that the block stays idle after done. Directed writes cover the all-zero and all-one pointers in both styles and for both lanes.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ADDR  = 3'd1,
      PH_LATCH = 3'd2,
      PH_DATA  = 3'd3,
      PH_REL   = 3'd4
   } phase_e;

   localparam int STYLE_RUNTIME = 0;
   localparam int STYLE_FLASH   = 1;
   localparam int STYLE_SRAM    = 2;
endpackage

// File: rtl/bsw_seq.sv
module bsw_seq
   import bsw_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   output phase_e phase_o,
   output logic   cap_o,
   output logic   done_o
);
   phase_e phase_q, phase_d;
   logic   done_q;

   assign cap_o = start_i && (phase_q == PH_IDLE);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (start_i) phase_d = PH_ADDR;
         PH_ADDR:  phase_d = PH_LATCH;
         PH_LATCH: phase_d = PH_DATA;
         PH_DATA:  phase_d = PH_REL;
         PH_REL:   phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= (phase_q == PH_REL);
      end
   end

   assign phase_o = phase_q;
   assign done_o  = done_q;

   // R10
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && start_i) |=> (phase_q != PH_ADDR));
   // R4
   data_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA) |=> (phase_q == PH_REL));
   // R3
   latch_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA) |-> ($past(phase_q) == PH_LATCH));
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (phase_q == PH_IDLE));
endmodule

// File: rtl/bsw_bus.sv
module bsw_bus
   import bsw_pkg::*;
#(
   parameter int PTR_W  = 21,
   parameter int AD_W   = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [DATA_W-1:0] data_i,
   input  phase_e            phase_i,
   output logic [AD_W-1:0]   ad_o,
   output logic              ad_oe_o,
   output logic [PTR_W-AD_W-$clog2(AD_W/DATA_W)-1:0] up_o,
   output logic [$clog2(AD_W/DATA_W)-1:0]            lane_o
);
   localparam int LANES  = AD_W / DATA_W;
   localparam int LANE_W = $clog2(LANES);
   localparam int UP_W   = PTR_W - AD_W - LANE_W;

   if (LANES * DATA_W != AD_W) begin : g_bad_lanes
      $error("bsw_bus: AD_W must be a multiple of DATA_W");
   end
   if (LANES < 2) begin : g_bad_count
      $error("bsw_bus: need at least two byte lanes");
   end
   if (UP_W < 1) begin : g_bad_ptr
      $error("bsw_bus: PTR_W too small for the AD width");
   end

   logic [PTR_W-1:0]  ptr_q;
   logic [DATA_W-1:0] data_q;
   logic [AD_W-1:0]   data_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         data_q <= '0;
      end else if (cap_i) begin
         ptr_q  <= ptr_i;
         data_q <= data_i;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_rep
      assign data_word[g*DATA_W +: DATA_W] = data_q;
   end

   always_comb begin
      ad_o    = '0;
      ad_oe_o = 1'b0;
      unique case (phase_i)
         PH_ADDR, PH_LATCH: begin
            ad_o    = ptr_q[LANE_W +: AD_W];
            ad_oe_o = 1'b1;
         end
         PH_DATA: begin
            ad_o    = data_word;
            ad_oe_o = 1'b1;
         end
         default: ;
      endcase
   end

   assign up_o   = (phase_i != PH_IDLE) ? ptr_q[PTR_W-1 -: UP_W] : '0;
   assign lane_o = ptr_q[LANE_W-1:0];

   // R11
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i != PH_IDLE && phase_i != PH_ADDR) |-> $stable(ptr_q));
   // R2
   addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_ADDR) |-> ad_oe_o);
endmodule

// File: rtl/bsw_lane.sv
module bsw_lane
   import bsw_pkg::*;
#(
   parameter int LANES = 2,
   parameter int STYLE = STYLE_RUNTIME
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_i,
   input  logic                     sram_mode_i,
   input  logic [$clog2(LANES)-1:0] lane_i,
   input  phase_e                   phase_i,
   output logic [LANES-1:0]         be_n_o,
   output logic [$clog2(LANES)-1:0] ba_o,
   output logic                     byte_mode_n_o
);
   localparam int LANE_W = $clog2(LANES);

   if (STYLE < STYLE_RUNTIME || STYLE > STYLE_SRAM) begin : g_bad_style
      $error("bsw_lane: unknown STYLE");
   end

   logic sram_eff;

   if (STYLE == STYLE_RUNTIME) begin : g_runtime
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     mode_q <= 1'b0;
         else if (cap_i) mode_q <= sram_mode_i;
      end
      assign sram_eff      = mode_q;
      assign byte_mode_n_o = sram_mode_i;
   end else begin : g_fixed
      assign sram_eff      = (STYLE == STYLE_SRAM);
      assign byte_mode_n_o = (STYLE == STYLE_SRAM);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_be
      assign be_n_o[g] = !(sram_eff && (phase_i == PH_DATA) && (lane_i == LANE_W'(g)));
   end

   assign ba_o = (!sram_eff && phase_i != PH_IDLE) ? lane_i : '0;

   // R6
   single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~be_n_o));
   // R7
   flash_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i != PH_IDLE && !sram_eff) |-> (&be_n_o));
endmodule

// File: rtl/bsw_wr_if.sv
module bsw_wr_if
   import bsw_pkg::*;
#(
   parameter int PTR_W  = 21,
   parameter int AD_W   = 16,
   parameter int DATA_W = 8,
   parameter int STYLE  = STYLE_RUNTIME,
   localparam int LANES  = AD_W / DATA_W,
   localparam int LANE_W = $clog2(LANES),
   localparam int UP_W   = PTR_W - AD_W - LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              sram_mode_i,
   output logic [AD_W-1:0]   ad_o,
   output logic              ad_oe_o,
   output logic [UP_W-1:0]   up_o,
   output logic              ale_o,
   output logic              wrh_n_o,
   output logic              wrl_n_o,
   output logic [LANE_W-1:0] ba_o,
   output logic [LANES-1:0]  be_n_o,
   output logic              byte_mode_n_o,
   output logic              busy_o,
   output logic              done_o
);
   phase_e            phase;
   logic              cap;
   logic [LANE_W-1:0] lane;

   bsw_seq i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .phase_o (phase),
      .cap_o   (cap),
      .done_o  (done_o)
   );

   bsw_bus #(.PTR_W(PTR_W), .AD_W(AD_W), .DATA_W(DATA_W)) i_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .ptr_i   (ptr_i),
      .data_i  (data_i),
      .phase_i (phase),
      .ad_o    (ad_o),
      .ad_oe_o (ad_oe_o),
      .up_o    (up_o),
      .lane_o  (lane)
   );

   bsw_lane #(.LANES(LANES), .STYLE(STYLE)) i_lane (
      .clk           (clk),
      .rst_n         (rst_n),
      .cap_i         (cap),
      .sram_mode_i   (sram_mode_i),
      .lane_i        (lane),
      .phase_i       (phase),
      .be_n_o        (be_n_o),
      .ba_o          (ba_o),
      .byte_mode_n_o (byte_mode_n_o)
   );

   assign ale_o   = (phase == PH_ADDR);
   assign wrh_n_o = (phase != PH_DATA);
   assign wrl_n_o = 1'b1;
   assign busy_o  = (phase != PH_IDLE);

   // R4
   strobe_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrh_n_o |-> (ad_oe_o && !ale_o && busy_o));
   // R4
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrh_n_o |=> wrh_n_o);
   // R6
   be_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&be_n_o) |-> !wrh_n_o);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R2
   ale_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_o) |-> $past(!busy_o));
endmodule

// File: tb/test_bsw_wr_if.sv
module test_bsw_wr_if;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [20:0] ptr = '0;
   logic [7:0]  data = '0;
   logic        sram = 1'b0;
   logic [15:0] ad_o;
   logic        ad_oe_o;
   logic [3:0]  up_o;
   logic        ale_o, wrh_n_o, wrl_n_o, byte_mode_n_o, busy_o, done_o;
   logic [0:0]  ba_o;
   logic [1:0]  be_n_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bsw_wr_if i_bsw_wr_if (
      .clk(clk), .rst_n(rst_n), .start_i(start), .ptr_i(ptr), .data_i(data),
      .sram_mode_i(sram), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .up_o(up_o),
      .ale_o(ale_o), .wrh_n_o(wrh_n_o), .wrl_n_o(wrl_n_o), .ba_o(ba_o),
      .be_n_o(be_n_o), .byte_mode_n_o(byte_mode_n_o), .busy_o(busy_o),
      .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [28:0] observed();
      return {ale_o, ad_oe_o, ad_o, up_o, wrh_n_o, wrl_n_o, ba_o, be_n_o, busy_o, done_o};
   endfunction

   // ph: 0 idle, 1 address, 2 latch, 3 data, 4 release, 5 done
   function automatic logic [28:0] expected(input int ph, input logic [20:0] p,
                                            input logic [7:0] d, input bit s);
      logic        ale, oe, wrh_n, ba, busy, done;
      logic [15:0] ad;
      logic [3:0]  up;
      logic [1:0]  be_n;
      bit          act;
      act   = (ph >= 1 && ph <= 4);
      ale   = (ph == 1);
      oe    = (ph >= 1 && ph <= 3);
      ad    = (ph == 1 || ph == 2) ? p[16:1] : (ph == 3) ? {d, d} : 16'h0;
      up    = act ? p[20:17] : 4'h0;
      wrh_n = (ph != 3);
      ba    = (act && !s) ? p[0] : 1'b0;
      be_n  = 2'b11;
      if (ph == 3 && s) be_n = p[0] ? 2'b01 : 2'b10;
      busy  = act;
      done  = (ph == 5);
      return {ale, oe, ad, up, wrh_n, 1'b1, ba, be_n, busy, done};
   endfunction

   task automatic phase_chk(input int ph, input string req, input logic [20:0] p,
                            input logic [7:0] d, input bit s);
      logic [28:0] e;
      e = expected(ph, p, d, s);
      chk(observed() == e, req, {3'b0, observed()}, {3'b0, e});
   endtask

   task automatic write_cycle(input logic [20:0] p, input logic [7:0] d,
                              input bit s, input bit disturb);
      @(negedge clk);
      ptr = p; data = d; sram = s; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(byte_mode_n_o == s, "R8 byte mode pin", {31'b0, byte_mode_n_o}, {31'b0, s});
      phase_chk(1, "R2 R7 address phase", p, d, s);
      if (disturb) begin
         start = 1'b1; ptr = ~p; data = ~d; sram = ~s;
      end
      @(negedge clk);
      phase_chk(2, "R3 R11 latch phase", p, d, s);
      @(negedge clk);
      phase_chk(3, "R4 R5 R6 R7 data phase", p, d, s);
      @(negedge clk);
      phase_chk(4, "R9 release phase", p, d, s);
      start = 1'b0;
      @(negedge clk);
      phase_chk(5, "R9 done pulse", p, d, s);
      @(negedge clk);
      phase_chk(0, "R1 R10 idle after cycle", p, d, s);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      phase_chk(0, "R1 in reset", '0, '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      phase_chk(0, "R1 after reset", '0, '0, 1'b0);
      chk(wrl_n_o == 1'b1, "R5 low strobe idle", {31'b0, wrl_n_o}, 32'd1);

      write_cycle(21'h000000, 8'h00, 1'b1, 1'b0);
      write_cycle(21'h1FFFFF, 8'hFF, 1'b1, 1'b0);
      write_cycle(21'h000000, 8'hA5, 1'b0, 1'b0);
      write_cycle(21'h1FFFFF, 8'h5A, 1'b0, 1'b0);
      write_cycle(21'h0AAAAA, 8'h3C, 1'b1, 1'b1);
      write_cycle(21'h155555, 8'hC3, 1'b0, 1'b1);

      void'($urandom(32'd24680));
      for (int i = 0; i < 60; i++) begin
         write_cycle(21'($urandom()), 8'($urandom()), 1'($urandom()),
                     ($urandom() % 3) == 0);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule